// File: doc/BRIEF.md
# Segment Base-Limit Address Translator

This block turns a logical address, made of a segment selector and an offset, into a physical address. It holds a small descriptor table in registers. Each descriptor has a base, a limit, a read-only flag and a present flag. The physical address is the base plus the offset. An access is refused with a fault code when the selector names no usable descriptor, when the offset runs past the limit, or when a write targets a read-only segment.

Descriptors are loaded one entry per clock through a write-enable port. The lookup path is purely combinational, so a request is answered in the same cycle in which it is presented. A flat-mode input makes every segment span the whole address space: bases read as zero and no limit applies, so a valid access returns the offset unchanged. The presence and read-only checks still apply in flat mode.

Top module: `seg_xlate_top`

## Requirements
- R1: For a request with no fault, `rsp_ok` is 1, `rsp_fault` is 0 and `rsp_paddr` equals the entry's base plus the offset, modulo 2^ADDR_W (base 0x2000 with offset 0x50 gives 0x2050).
- R2: When `cfg_we` is high at a rising clock edge, entry `cfg_idx` takes `cfg_base`, `cfg_limit`, `cfg_ro` and `cfg_present`, and lookups see the new values from the next cycle on. Other entries keep their contents, and a lookup in the same cycle as the write still sees the old contents.
- R3: Outside flat mode, an offset greater than or equal to the entry's limit gives fault code 2 (limit), with `rsp_ok` 0 and `rsp_paddr` 0.
- R4: A write request (`req_write` 1) to an entry whose read-only flag is set gives fault code 3 (write-protect). A read request to the same entry is translated normally.
- R5: A selector of SEG_COUNT or more, or a selector whose entry has its present flag clear, gives fault code 1 (invalid segment).
- R6: When several faults apply, the invalid-segment fault wins over the limit fault, and the limit fault wins over the write-protect fault.
- R7: With `flat_mode` high, every base reads as zero and no limit check is made, so a request with no fault returns `rsp_paddr` equal to `req_offset`. The present and read-only checks still apply.
- R8: Reset clears every entry's present flag, so after reset every request gives fault code 1.
- R9: With `req_valid` low, `rsp_valid`, `rsp_ok`, `rsp_fault` and `rsp_paddr` are all 0.
- R10: The response is combinational. It reflects the request and the table contents of the same cycle, with `rsp_valid` equal to `req_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the descriptor registers |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Load a descriptor this cycle |
| cfg_idx | input | IDX_W (2) | Entry to load |
| cfg_base | input | ADDR_W (32) | Base to load |
| cfg_limit | input | ADDR_W (32) | Limit (segment length) to load |
| cfg_ro | input | 1 | Read-only flag to load |
| cfg_present | input | 1 | Present flag to load |
| flat_mode | input | 1 | Zero bases, no limit check |
| req_valid | input | 1 | Request present |
| req_seg | input | SEL_W (3) | Segment selector |
| req_offset | input | ADDR_W (32) | Offset within the segment |
| req_write | input | 1 | Access is a write |
| rsp_valid | output | 1 | Response present |
| rsp_ok | output | 1 | Translation succeeded |
| rsp_fault | output | 2 | 0 none, 1 invalid segment, 2 limit, 3 write-protect |
| rsp_paddr | output | ADDR_W (32) | Physical address, 0 on fault |

## Verification
The assertions assume that request and configuration inputs are stable and known around each rising edge, and that `cfg_idx` always names an existing entry. They also assume that `req_seg` is compared against descriptors that were loaded under reset-free operation. The bench changes every input only just after the falling edge and samples the response one nanosecond later, well before the next rising edge. It picks `cfg_idx` only from 0 to SEG_COUNT-1, while `req_seg` deliberately covers the whole selector range, including values past the table.

// File: rtl/seg_xlate_pkg.sv
`timescale 1ns/1ps
package seg_xlate_pkg;

  typedef enum logic [1:0] {
    FLT_NONE   = 2'd0,
    FLT_BADSEG = 2'd1,
    FLT_LIMIT  = 2'd2,
    FLT_WPROT  = 2'd3
  } flt_e;

  // Priority encoder: bad segment, then limit, then write protection.
  function automatic flt_e pick_fault(input logic bad, input logic over, input logic wp);
    if (bad)       return FLT_BADSEG;
    else if (over) return FLT_LIMIT;
    else if (wp)   return FLT_WPROT;
    else           return FLT_NONE;
  endfunction

endpackage

// File: rtl/seg_table.sv
`timescale 1ns/1ps
module seg_table #(
  parameter int SEG_COUNT = 4,
  parameter int ADDR_W    = 32,
  parameter int SEL_W     = 3,
  localparam int IDX_W    = $clog2(SEG_COUNT)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [IDX_W-1:0]  cfg_idx,
  input  logic [ADDR_W-1:0] cfg_base,
  input  logic [ADDR_W-1:0] cfg_limit,
  input  logic              cfg_ro,
  input  logic              cfg_present,
  input  logic              flat_mode,
  input  logic [SEL_W-1:0]  rd_sel,
  output logic [ADDR_W-1:0] rd_base,
  output logic [ADDR_W-1:0] rd_limit,
  output logic              rd_unbounded,
  output logic              rd_ro,
  output logic              rd_present,
  output logic              rd_in_range
);

  logic [ADDR_W-1:0] ent_base  [SEG_COUNT];
  logic [ADDR_W-1:0] ent_limit [SEG_COUNT];
  logic              ent_ro    [SEG_COUNT];
  logic              ent_pres  [SEG_COUNT];

  for (genvar g = 0; g < SEG_COUNT; g++) begin : g_ent
    logic hit_wr;
    assign hit_wr = cfg_we && (cfg_idx == IDX_W'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        ent_base[g]  <= '0;
        ent_limit[g] <= '0;
        ent_ro[g]    <= 1'b0;
        ent_pres[g]  <= 1'b0;
      end else if (hit_wr) begin
        ent_base[g]  <= cfg_base;
        ent_limit[g] <= cfg_limit;
        ent_ro[g]    <= cfg_ro;
        ent_pres[g]  <= cfg_present;
      end
    end
  end

  logic [ADDR_W-1:0] sel_base;
  logic [ADDR_W-1:0] sel_limit;
  logic              sel_ro;
  logic              sel_pres;

  always_comb begin
    sel_base  = '0;
    sel_limit = '0;
    sel_ro    = 1'b0;
    sel_pres  = 1'b0;
    for (int i = 0; i < SEG_COUNT; i++) begin
      if (rd_sel == SEL_W'(i)) begin
        sel_base  = ent_base[i];
        sel_limit = ent_limit[i];
        sel_ro    = ent_ro[i];
        sel_pres  = ent_pres[i];
      end
    end
  end

  assign rd_in_range  = ({1'b0, rd_sel} < (SEL_W+1)'(SEG_COUNT));
  assign rd_base      = flat_mode ? '0 : sel_base;
  assign rd_limit     = flat_mode ? '1 : sel_limit;
  assign rd_unbounded = flat_mode;
  assign rd_ro        = sel_ro;
  assign rd_present   = sel_pres;

endmodule

// File: rtl/seg_check.sv
`timescale 1ns/1ps
module seg_check
  import seg_xlate_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_offset,
  input  logic              req_write,
  input  logic              in_range,
  input  logic              present,
  input  logic              ro,
  input  logic              unbounded,
  input  logic [ADDR_W-1:0] base,
  input  logic [ADDR_W-1:0] limit,
  output logic              ev_badseg,
  output logic              ev_over,
  output logic              ev_wprot,
  output logic              ok,
  output flt_e              fault,
  output logic [ADDR_W-1:0] paddr
);

  function automatic logic [ADDR_W-1:0] wrap_add(input logic [ADDR_W-1:0] a,
                                                 input logic [ADDR_W-1:0] b);
    return a + b;
  endfunction

  function automatic logic past_limit(input logic [ADDR_W-1:0] off,
                                      input logic [ADDR_W-1:0] lim,
                                      input logic no_bound);
    return !no_bound && (off >= lim);
  endfunction

  assign ev_badseg = req_valid && !(in_range && present);
  assign ev_over   = req_valid && past_limit(req_offset, limit, unbounded);
  assign ev_wprot  = req_valid && req_write && ro;

  always_comb begin
    fault = FLT_NONE;
    if (req_valid) fault = pick_fault(ev_badseg, ev_over, ev_wprot);
  end

  assign ok    = req_valid && (fault == FLT_NONE);
  assign paddr = ok ? wrap_add(base, req_offset) : '0;

endmodule

// File: rtl/seg_xlate_top.sv
`timescale 1ns/1ps
module seg_xlate_top
  import seg_xlate_pkg::*;
#(
  parameter int SEG_COUNT = 4,
  parameter int ADDR_W    = 32,
  parameter int SEL_W     = 3,
  localparam int IDX_W    = $clog2(SEG_COUNT)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [IDX_W-1:0]  cfg_idx,
  input  logic [ADDR_W-1:0] cfg_base,
  input  logic [ADDR_W-1:0] cfg_limit,
  input  logic              cfg_ro,
  input  logic              cfg_present,
  input  logic              flat_mode,
  input  logic              req_valid,
  input  logic [SEL_W-1:0]  req_seg,
  input  logic [ADDR_W-1:0] req_offset,
  input  logic              req_write,
  output logic              rsp_valid,
  output logic              rsp_ok,
  output logic [1:0]        rsp_fault,
  output logic [ADDR_W-1:0] rsp_paddr
);

  logic [ADDR_W-1:0] t_base;
  logic [ADDR_W-1:0] t_limit;
  logic              t_unbounded;
  logic              t_ro;
  logic              t_present;
  logic              t_in_range;
  logic              ev_badseg;
  logic              ev_over;
  logic              ev_wprot;
  flt_e              fault_code;

  seg_table #(
    .SEG_COUNT (SEG_COUNT),
    .ADDR_W    (ADDR_W),
    .SEL_W     (SEL_W)
  ) u_table (
    .clk          (clk),
    .rst_n        (rst_n),
    .cfg_we       (cfg_we),
    .cfg_idx      (cfg_idx),
    .cfg_base     (cfg_base),
    .cfg_limit    (cfg_limit),
    .cfg_ro       (cfg_ro),
    .cfg_present  (cfg_present),
    .flat_mode    (flat_mode),
    .rd_sel       (req_seg),
    .rd_base      (t_base),
    .rd_limit     (t_limit),
    .rd_unbounded (t_unbounded),
    .rd_ro        (t_ro),
    .rd_present   (t_present),
    .rd_in_range  (t_in_range)
  );

  seg_check #(
    .ADDR_W (ADDR_W)
  ) u_check (
    .req_valid  (req_valid),
    .req_offset (req_offset),
    .req_write  (req_write),
    .in_range   (t_in_range),
    .present    (t_present),
    .ro         (t_ro),
    .unbounded  (t_unbounded),
    .base       (t_base),
    .limit      (t_limit),
    .ev_badseg  (ev_badseg),
    .ev_over    (ev_over),
    .ev_wprot   (ev_wprot),
    .ok         (rsp_ok),
    .fault      (fault_code),
    .paddr      (rsp_paddr)
  );

  assign rsp_valid = req_valid;
  assign rsp_fault = fault_code;

endmodule

// File: rtl/seg_xlate_chk.sv
`timescale 1ns/1ps
module seg_xlate_chk #(
  parameter int SEG_COUNT = 4,
  parameter int ADDR_W    = 32,
  parameter int SEL_W     = 3,
  localparam int IDX_W    = $clog2(SEG_COUNT)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cfg_we,
  input logic [IDX_W-1:0]  cfg_idx,
  input logic [ADDR_W-1:0] cfg_base,
  input logic              flat_mode,
  input logic              req_valid,
  input logic [SEL_W-1:0]  req_seg,
  input logic [ADDR_W-1:0] req_offset,
  input logic              req_write,
  input logic              rsp_valid,
  input logic              rsp_ok,
  input logic [1:0]        rsp_fault,
  input logic [ADDR_W-1:0] rsp_paddr,
  input logic              ev_badseg,
  input logic              ev_over
);

  // R1: success and fault code are mutually exclusive on a live response
  a_r1_ok_excl: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (rsp_ok == (rsp_fault == 2'd0)));

  // R5: selector past the table always reports an invalid segment
  a_r5_range: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && ({1'b0, req_seg} >= (SEL_W+1)'(SEG_COUNT))) |-> (rsp_fault == 2'd1));

  // R4: write protection is only ever reported for writes
  a_r4_wp_write: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_fault == 2'd3) |-> req_write);

  // R6: an offset overrun hides a write-protect fault
  a_r6_prio: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_over && !ev_badseg) |-> (rsp_fault == 2'd2));

  // R7: flat mode passes the offset through
  a_r7_flat: assert property (@(posedge clk) disable iff (!rst_n)
    (flat_mode && rsp_ok) |-> (rsp_paddr == req_offset));

  // R9: idle request leaves the response quiet
  a_r9_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |-> (!rsp_valid && !rsp_ok && rsp_fault == 2'd0 && rsp_paddr == '0));

  // R2: a loaded base is used from the next cycle on
  a_r2_load_seen: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(cfg_we) && req_valid && !flat_mode && rsp_ok &&
     req_seg == SEL_W'($past(cfg_idx)))
    |-> (rsp_paddr == $past(cfg_base) + req_offset));

endmodule

bind seg_xlate_top seg_xlate_chk #(
  .SEG_COUNT (SEG_COUNT),
  .ADDR_W    (ADDR_W),
  .SEL_W     (SEL_W)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cfg_we     (cfg_we),
  .cfg_idx    (cfg_idx),
  .cfg_base   (cfg_base),
  .flat_mode  (flat_mode),
  .req_valid  (req_valid),
  .req_seg    (req_seg),
  .req_offset (req_offset),
  .req_write  (req_write),
  .rsp_valid  (rsp_valid),
  .rsp_ok     (rsp_ok),
  .rsp_fault  (rsp_fault),
  .rsp_paddr  (rsp_paddr),
  .ev_badseg  (ev_badseg),
  .ev_over    (ev_over)
);

// File: tb/test_seg_xlate_top.sv
`timescale 1ns/1ps
module test_seg_xlate_top;

  localparam int NSEG = 4;
  localparam int AW   = 32;
  localparam int SW   = 3;
  localparam int IW   = 2;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cfg_we = 1'b0;
  logic [IW-1:0] cfg_idx = '0;
  logic [AW-1:0] cfg_base = '0;
  logic [AW-1:0] cfg_limit = '0;
  logic          cfg_ro = 1'b0;
  logic          cfg_present = 1'b0;
  logic          flat_mode = 1'b0;
  logic          req_valid = 1'b0;
  logic [SW-1:0] req_seg = '0;
  logic [AW-1:0] req_offset = '0;
  logic          req_write = 1'b0;
  logic          rsp_valid;
  logic          rsp_ok;
  logic [1:0]    rsp_fault;
  logic [AW-1:0] rsp_paddr;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  // reference table
  longint m_base [NSEG];
  longint m_lim  [NSEG];
  bit     m_ro   [NSEG];
  bit     m_pres [NSEG];

  always #2.5 clk = ~clk;

  seg_xlate_top i_seg_xlate_top (
    .clk, .rst_n, .cfg_we, .cfg_idx, .cfg_base, .cfg_limit, .cfg_ro, .cfg_present,
    .flat_mode, .req_valid, .req_seg, .req_offset, .req_write,
    .rsp_valid, .rsp_ok, .rsp_fault, .rsp_paddr
  );

  task automatic compare(input string tag);
    bit     e_v, e_ok;
    int     e_f;
    longint e_pa;
    int     s;
    s    = int'(req_seg);
    e_v  = req_valid;
    e_ok = 0;
    e_f  = 0;
    e_pa = 0;
    if (req_valid) begin
      if (s >= NSEG || !m_pres[s]) e_f = 1;
      else if (!flat_mode && longint'(req_offset) >= m_lim[s]) e_f = 2;
      else if (req_write && m_ro[s]) e_f = 3;
      else begin
        e_ok = 1;
        e_pa = ((flat_mode ? 0 : m_base[s]) + longint'(req_offset)) % 64'h1_0000_0000;
      end
    end
    checks++;
    if (rsp_valid !== e_v || rsp_ok !== e_ok || int'(rsp_fault) != e_f ||
        longint'(rsp_paddr) != e_pa) begin
      failures++;
      $display("FAIL %s: got v=%0b ok=%0b f=%0d pa=%h, expected v=%0b ok=%0b f=%0d pa=%h",
               tag, rsp_valid, rsp_ok, rsp_fault, rsp_paddr, e_v, e_ok, e_f, e_pa[31:0]);
    end
  endtask

  // One cycle: drive after falling edge, check, then apply load to model at rising edge.
  task automatic step(input bit we, input int idx, input longint b, input longint l,
                      input bit ro, input bit pr, input bit flat, input bit rv,
                      input int seg, input longint off, input bit wr, input string tag);
    @(negedge clk);
    cfg_we = we; cfg_idx = IW'(idx); cfg_base = AW'(b); cfg_limit = AW'(l);
    cfg_ro = ro; cfg_present = pr; flat_mode = flat;
    req_valid = rv; req_seg = SW'(seg); req_offset = AW'(off); req_write = wr;
    #1;
    compare(tag);
    @(posedge clk);
    if (we) begin
      m_base[idx] = b; m_lim[idx] = l; m_ro[idx] = ro; m_pres[idx] = pr;
    end
  endtask

  task automatic load(input int idx, input longint b, input longint l, input bit ro, input bit pr);
    step(1, idx, b, l, ro, pr, 0, 0, 0, 0, 0, "R2 load");
  endtask

  task automatic look(input bit flat, input int seg, input longint off, input bit wr, input string tag);
    step(0, 0, 0, 0, 0, 0, flat, 1, seg, off, wr, tag);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog: got hung run, expected completion");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < NSEG; i++) begin
      m_base[i] = 0; m_lim[i] = 0; m_ro[i] = 0; m_pres[i] = 0;
    end
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R8: empty table after reset
    look(0, 0, 0, 0, "R8 reset seg0");
    look(0, 3, 4, 0, "R8 reset seg3");
    // R9: idle
    step(0, 0, 0, 0, 0, 0, 0, 0, 2, 12, 1, "R9 idle");

    load(0, 64'h1000, 64'h400, 1, 1);
    load(1, 64'h2000, 64'h300, 0, 1);
    load(2, 64'h3000, 64'h200, 0, 1);
    load(3, 64'h4000, 64'h100, 0, 0);

    look(0, 1, 64'h50,  0, "R1 seg1+0x50");
    look(0, 2, 64'h1FF, 1, "R1 seg2 top byte");
    look(0, 1, 64'h300, 0, "R3 at limit");
    look(0, 1, 64'h2FF, 0, "R3 below limit");
    look(0, 0, 64'h10,  1, "R4 write to ro");
    look(0, 0, 64'h10,  0, "R4 read of ro");
    look(0, 3, 64'h10,  0, "R5 not present");
    look(0, 5, 64'h10,  0, "R5 out of range");
    look(0, 7, 64'hFFFF_FFFF, 1, "R6 badseg over limit");
    look(0, 0, 64'h400, 1, "R6 limit over wprot");
    look(1, 1, 64'h1234_5678, 0, "R7 flat passthru");
    look(1, 0, 64'hFFFF_FFFF, 0, "R7 flat no limit");
    look(1, 0, 64'h20, 1, "R7 flat keeps ro");
    look(1, 3, 64'h20, 0, "R7 flat keeps present");

    // R1 wraparound
    load(2, 64'hFFFF_FF00, 64'h1000, 0, 1);
    look(0, 2, 64'h200, 0, "R1 wrap");
    look(0, 1, 64'h50,  0, "R2 other entry kept");
    // R2/R10: lookup in the load cycle sees old contents
    step(1, 1, 64'h8000, 64'h10, 0, 1, 0, 1, 1, 64'h50, 0, "R10 same-cycle old value");
    look(0, 1, 64'h50, 0, "R2 new limit applied");
    look(0, 1, 64'h8,  0, "R2 new base applied");

    for (int n = 0; n < 400; n++) begin
      bit we;
      we = ($urandom_range(0, 3) == 0);
      step(we, $urandom_range(0, NSEG-1), longint'($urandom), longint'($urandom_range(0, 16'h800)),
           $urandom_range(0, 1), ($urandom_range(0, 3) != 0), ($urandom_range(0, 4) == 0),
           ($urandom_range(0, 7) != 0), $urandom_range(0, 7), longint'($urandom_range(0, 16'h900)),
           $urandom_range(0, 1), "R1 random mix");
    end

    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule